// File: doc/BRIEF.md
# SPI Serial Hold Gate

This block sits between the pins of an SPI slave and its serial core and lets the host pause a transaction without losing it. It samples the serial clock, the active-low chip select and the active-low hold input in the system clock domain. It turns each serial clock edge into a single-cycle enable pulse for the core: one pulse for rising edges, where SI is sampled, and one for falling edges, where SO is shifted. While a pause is in force, it stops those pulses, so the core's bit counter and shift register stay exactly where they were. It also drives an output-enable for the SO driver. That enable drops as soon as hold is pulled low, even before any pause takes effect.

A pause can start only once the device is selected and the first serial clock rising edge of the sequence has been seen. If hold is pulled low while the serial clock is low, the pause starts at once. If hold is pulled low while the serial clock is high, the pause starts at the next falling edge, and that falling edge is not passed to the core. Releasing hold resumes the transfer only if the serial clock is low at that moment. A release made while the clock is high leaves the block paused until hold is pulsed low and high again with the clock low. Raising chip select ends the transaction and clears any pause.

Top module: `spi_hold_gate`

## Requirements
- R1: After reset, paused, so_oe, sck_rise_en and sck_fall_en are all 0.
- R2: While selected and not paused, each rising edge of sck gives exactly one single-cycle sck_rise_en pulse, and each falling edge gives exactly one sck_fall_en pulse.
- R3: While cs_n is high, sck edges produce no enable pulses and so_oe is 0.
- R4: During a sequence that is underway (at least one rise pulse since selection), hold_n going low while sck is low sets paused to 1. While paused, sck edges produce no pulses and so_oe is 0.
- R5: hold_n going low while sck is high does not pause until the next sck falling edge. At that edge paused becomes 1 and no sck_fall_en pulse is issued.
- R6: A rising edge of hold_n while sck is low clears paused, and edge pulses resume.
- R7: A rising edge of hold_n while sck is high leaves paused at 1. A later low-then-high cycle of hold_n with sck low clears it.
- R8: so_oe falls combinationally when hold_n is low, with no clock edge needed.
- R9: Raising cs_n clears paused and ends the sequence. The next selection starts unpaused.
- R10: hold_n low after selection but before the first rising sck edge does not set paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock pin |
| cs_n | input | 1 | Active-low chip select pin |
| hold_n | input | 1 | Active-low pause request pin |
| sck_rise_en | output | 1 | One-cycle enable for the core's SI sampling |
| sck_fall_en | output | 1 | One-cycle enable for the core's SO shifting |
| so_oe | output | 1 | SO driver enable (0 means high impedance) |
| paused | output | 1 | Pause in force |

## Verification
The bench builds the block with SYNC_STAGES at its default of 2, so every pin change shows up at the outputs within a few system clocks. This keeps every ordering of sck, hold_n and cs_n in reach with short settle windows. The table drives the immediate pause, the deferred pause, resume with sck low, the refused resume with sck high, deselect during a pause and a hold before the first edge. It checks paused and so_oe, and it checks cumulative edge-pulse counts after each step, so that a swallowed or extra pulse is caught.

// File: rtl/spi_hold_gate.sv
module spi_hold_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic hold_n,
  output logic sck_rise_en,
  output logic sck_fall_en,
  output logic so_oe,
  output logic paused
);
  localparam int W = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [W-1:0] sck_p, cs_p, hold_p;
  logic sck_s, cs_s, hold_s;
  logic sck_d, hold_d;
  logic active;
  logic sel, sck_rise, sck_fall, hold_rise, enter, leave;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      cs_p   <= '1;
      hold_p <= '1;
      sck_d  <= 1'b0;
      hold_d <= 1'b1;
    end else begin
      sck_p  <= {sck_p[W-2:0], sck};
      cs_p   <= {cs_p[W-2:0], cs_n};
      hold_p <= {hold_p[W-2:0], hold_n};
      sck_d  <= sck_s;
      hold_d <= hold_s;
    end
  end

  assign sck_s  = sck_p[W-1];
  assign cs_s   = cs_p[W-1];
  assign hold_s = hold_p[W-1];

  assign sel       = ~cs_s;
  assign sck_rise  = sck_s & ~sck_d;
  assign sck_fall  = ~sck_s & sck_d;
  assign hold_rise = hold_s & ~hold_d;

  assign enter = sel & active & ~paused & ~hold_s & ~sck_s;
  assign leave = paused & hold_rise & ~sck_s;

  assign sck_rise_en = sel & sck_rise & ~paused;
  assign sck_fall_en = sel & sck_fall & ~paused & ~enter;
  assign so_oe       = ~cs_n & hold_n & sel & ~paused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      paused <= 1'b0;
    end else if (!sel) begin
      active <= 1'b0;
      paused <= 1'b0;
    end else begin
      if (sck_rise_en) active <= 1'b1;
      if (enter)       paused <= 1'b1;
      else if (leave)  paused <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_hold_gate_chk.sv
module spi_hold_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic sck_s,
  input logic hold_s,
  input logic sck_rise_en,
  input logic sck_fall_en,
  input logic paused
);
  p_single_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise_en |=> !sck_rise_en);
  p_single_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sck_fall_en |=> !sck_fall_en);
  p_edge_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_rise_en && sck_fall_en));
  p_enter_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> (!$past(sck_s) && !$past(hold_s)));
  p_resume_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(paused) && !$past(cs_s)) |-> (!$past(sck_s) && $past(hold_s)));
  p_deselect_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !paused);
endmodule

bind spi_hold_gate spi_hold_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_s(sck_s), .hold_s(hold_s),
  .sck_rise_en(sck_rise_en), .sck_fall_en(sck_fall_en), .paused(paused)
);

// File: tb/spi_hold_gate_test.sv
module spi_hold_gate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1;
  logic sck_rise_en, sck_fall_en, so_oe, paused;
  int checks = 0, errors = 0;
  int n_rise = 0, n_fall = 0;
  logic clr = 1'b1;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  spi_hold_gate #(.SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
    .sck_rise_en(sck_rise_en), .sck_fall_en(sck_fall_en),
    .so_oe(so_oe), .paused(paused)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      n_rise <= 0;
      n_fall <= 0;
    end else begin
      if (sck_rise_en) n_rise <= n_rise + 1;
      if (sck_fall_en) n_fall <= n_fall + 1;
    end
  end

  typedef struct packed {
    logic sck, cs_n, hold_n, paused, oe;
    logic [3:0] rises, falls;
  } step_t;

  localparam int NSTEP = 28;
  localparam step_t TBL [NSTEP] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b1,4'd0,4'd0}, // R2 select
    '{1'b1,1'b0,1'b1,1'b0,1'b1,4'd1,4'd0}, // R2 rise
    '{1'b0,1'b0,1'b1,1'b0,1'b1,4'd1,4'd1}, // R2 fall
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'd1,4'd1}, // R4 hold with sck low
    '{1'b1,1'b0,1'b0,1'b1,1'b0,4'd1,4'd1}, // R4 edge ignored
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'd1,4'd1}, // R4 edge ignored
    '{1'b0,1'b0,1'b1,1'b0,1'b1,4'd1,4'd1}, // R6 resume sck low
    '{1'b1,1'b0,1'b1,1'b0,1'b1,4'd2,4'd1}, // R6 edges back
    '{1'b1,1'b0,1'b0,1'b0,1'b0,4'd2,4'd1}, // R5 deferred, R8 oe off
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'd2,4'd1}, // R5 pause at fall, no pulse
    '{1'b1,1'b0,1'b0,1'b1,1'b0,4'd2,4'd1}, // R4
    '{1'b1,1'b0,1'b1,1'b1,1'b0,4'd2,4'd1}, // R7 release with sck high
    '{1'b0,1'b0,1'b1,1'b1,1'b0,4'd2,4'd1}, // R7 still paused
    '{1'b1,1'b0,1'b1,1'b1,1'b0,4'd2,4'd1}, // R7
    '{1'b0,1'b0,1'b1,1'b1,1'b0,4'd2,4'd1}, // R7
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'd2,4'd1}, // R7 re-cycle low
    '{1'b0,1'b0,1'b1,1'b0,1'b1,4'd2,4'd1}, // R7 re-cycle high resumes
    '{1'b1,1'b0,1'b1,1'b0,1'b1,4'd3,4'd1}, // R2
    '{1'b0,1'b0,1'b1,1'b0,1'b1,4'd3,4'd2}, // R2
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'd3,4'd2}, // R4
    '{1'b0,1'b1,1'b0,1'b0,1'b0,4'd3,4'd2}, // R9 deselect clears
    '{1'b1,1'b1,1'b1,1'b0,1'b0,4'd3,4'd2}, // R3 no pulse
    '{1'b0,1'b1,1'b1,1'b0,1'b0,4'd3,4'd2}, // R3 no pulse
    '{1'b0,1'b0,1'b1,1'b0,1'b1,4'd3,4'd2}, // R9 fresh selection
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'd3,4'd2}, // R10 hold before first edge
    '{1'b0,1'b0,1'b1,1'b0,1'b1,4'd3,4'd2}, // R10
    '{1'b1,1'b0,1'b1,1'b0,1'b1,4'd4,4'd2}, // R2
    '{1'b0,1'b0,1'b1,1'b0,1'b1,4'd4,4'd3}  // R2
  };

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {6'd0, paused, so_oe, sck_rise_en, sck_fall_en}, 10'd0);
    rst_n = 1'b1;
    settle();
    check("R1", {6'd0, paused, so_oe, sck_rise_en, sck_fall_en}, 10'd0);
    clr = 1'b0;
    for (int i = 0; i < NSTEP; i++) begin
      sck = TBL[i].sck;
      cs_n = TBL[i].cs_n;
      hold_n = TBL[i].hold_n;
      settle();
      check($sformatf("step %0d", i),
            {paused, so_oe, n_rise[3:0], n_fall[3:0]},
            {TBL[i].paused, TBL[i].oe, TBL[i].rises, TBL[i].falls});
    end
    // R8 so_oe falls with no clock edge
    hold_n = 1'b0;
    #1;
    check("R8", {9'd0, so_oe}, 10'd0);
    settle();
    check("R4", {9'd0, paused}, 10'd1);
    hold_n = 1'b1;
    settle();
    check("R6", {8'd0, paused, so_oe}, 10'b01);
    // R3 deselect drops oe at once
    cs_n = 1'b1;
    #1;
    check("R3", {9'd0, so_oe}, 10'd0);
    settle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule